// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital control logic wrapped around a 10-bit successive-approximation converter. It picks one of four trigger sources (a software start bit or one of three timer outputs), can invert the chosen trigger, and detects its rising edge. It then opens a sample window measured in converter clock ticks. After that it hands a start pulse to the converter and waits for the converter's done pulse and 10-bit result.

Four sequence modes decide which channel comes next and whether the controller stops or starts again. In the scan modes the channel counts down from a programmed top channel to channel 0. An auto-continue option starts each later conversion as soon as the previous one completes, with no new trigger edge needed. Each result is stored right-justified in a 16-bit register, either as straight binary or as sign-extended two's complement. Every load raises an interrupt flag. The controller also reports a busy status.

All control settings arrive as register-style levels. The converter is modelled as a start/done handshake, and `cv_tick` marks one converter clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Synchronous active-low reset: while `rst_n` is low and after it rises, `busy`, `sample_win`, `cv_start`, `irq_flag`, `irq_req` are 0, `result` is 0 and `chan_sel` is 0.
- R2: `cfg_src` chooses the trigger: code 0 is the software start `sw_go`, latched into a start bit that clears itself one cycle later. Codes 1, 2 and 3 are `tmr_trig[0]`, `tmr_trig[1]` and `tmr_trig[2]`. `cfg_src_inv`=1 inverts the chosen signal before rising-edge detection. Edges on an input that is not selected start nothing.
- R3: While `cfg_enable` is 0, trigger edges are ignored and no `cv_start` is issued. `sw_go` may be pulsed in the same cycle that `cfg_enable` is raised.
- R4: `sample_win` stays high for 4, 8, 16 or 64 cycles in which `cv_tick` is 1, for `cfg_hold` = 0, 1, 2 or 3. Cycles with `cv_tick`=0 extend the window. When the window ends, `cv_start` pulses for exactly one cycle.
- R5: `cfg_mode`=0 converts channel `cfg_chan` once and then returns to idle.
- R6: `cfg_mode`=1 converts `cfg_chan`, `cfg_chan`-1, ... down to 0 once and then returns to idle.
- R7: `cfg_mode`=2 repeats conversions of `cfg_chan`. `cfg_mode`=3 repeats the downward scan and reloads `cfg_chan` after channel 0.
- R8: With `cfg_auto`=0, each conversion after the first needs its own trigger edge. With `cfg_auto`=1 in modes 1 to 3, the next sample window opens in the cycle after the previous conversion's done.
- R9: Clearing `cfg_enable` lets a conversion already handed to the converter finish and load, and then stops. A sample window still open is abandoned without `cv_start`.
- R10: `cfg_signed`=0 stores the 10-bit result zero-extended to 16 bits. `cfg_signed`=1 stores it with bit 9 inverted and then sign-extended from bit 9.
- R11: `irq_flag` is set by every result load and cleared by `irq_ack` or `flag_clear`. A load in the same cycle as a clear leaves the flag set. `irq_req` equals `irq_flag` AND `cfg_irq_en`.
- R12: `busy` is high from an accepted trigger until the sequence ends. This includes the time spent waiting for the next trigger between steps of a scan or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Conversion enable |
| sw_go | input | 1 | Software start request, one-cycle pulse |
| cfg_mode | input | 2 | Sequence mode |
| cfg_chan | input | 4 | Channel to convert, or top channel of a scan |
| cfg_auto | input | 1 | Auto-continue after each conversion |
| cfg_hold | input | 2 | Sample window length select |
| cfg_src | input | 2 | Trigger source select |
| cfg_src_inv | input | 1 | Invert selected trigger |
| cfg_signed | input | 1 | Two's-complement result format |
| cfg_irq_en | input | 1 | Interrupt request enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears flag |
| flag_clear | input | 1 | Software flag clear |
| tmr_trig | input | 3 | Timer trigger outputs |
| cv_tick | input | 1 | Converter clock tick |
| cv_start | output | 1 | Conversion start pulse to converter |
| cv_done | input | 1 | Conversion done pulse from converter |
| cv_data | input | 10 | Conversion result from converter |
| chan_sel | output | 4 | Channel being sampled and converted |
| sample_win | output | 1 | Sample window open |
| busy | output | 1 | Sequence, sample or conversion in progress |
| result | output | 16 | Formatted result register |
| irq_flag | output | 1 | Result-loaded flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Two things can happen in the same cycle: a result load and a flag clear. The bench provokes this by pulsing `irq_ack` in exactly the cycle where its converter model raises `cv_done`. It then judges that `irq_flag` still reads 1 afterwards, and that a lone acknowledge later clears it. A second overlap is also tested: an enable drop while a conversion or sample is in flight. The bench requires that every issued `cv_start` produced a loaded result and that no new window opened.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_ONE      = 2'd0,
      SEQ_SCAN     = 2'd1,
      SEQ_REP_ONE  = 2'd2,
      SEQ_REP_SCAN = 2'd3
   } seq_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2,
      ST_WAIT   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
   parameter int NTMR  = 3,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_go,
   input  logic [NTMR-1:0]  tmr_trig,
   input  logic [SEL_W-1:0] src,
   input  logic             src_inv,
   output logic             trig_rise
);
   localparam int NSRC = NTMR + 1;

   if (NSRC > (1 << SEL_W)) begin : g_bad_sel
      $error("adc_trig_sel: SEL_W too narrow for NTMR sources");
   end

   logic            sw_bit;
   logic [NSRC-1:0] srcv;
   logic            picked, lvl, lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sw_bit <= 1'b0;
      else        sw_bit <= sw_go;
   end

   assign srcv = {tmr_trig, sw_bit};

   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < NSRC; i++)
         if (int'(src) == i) picked = srcv[i];
   end

   assign lvl = picked ^ src_inv;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign trig_rise = lvl & ~lvl_q;

   // R2
   sw_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_bit |-> $past(sw_go));
endmodule

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
   parameter int HOLD0 = 4,
   parameter int HOLD1 = 8,
   parameter int HOLD2 = 16,
   parameter int HOLD3 = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       done
);
   localparam int HMAX01 = (HOLD0 > HOLD1) ? HOLD0 : HOLD1;
   localparam int HMAX23 = (HOLD2 > HOLD3) ? HOLD2 : HOLD3;
   localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
   localparam int CNT_W  = $clog2(HMAX + 1);

   if (HOLD0 < 1 || HOLD1 < 1 || HOLD2 < 1 || HOLD3 < 1) begin : g_bad_hold
      $error("adc_sample_timer: every window length must be at least 1");
   end

   logic [CNT_W-1:0] cnt, lim_m1;

   always_comb begin
      unique case (sel)
         2'd0:    lim_m1 = CNT_W'(HOLD0 - 1);
         2'd1:    lim_m1 = CNT_W'(HOLD1 - 1);
         2'd2:    lim_m1 = CNT_W'(HOLD2 - 1);
         default: lim_m1 = CNT_W'(HOLD3 - 1);
      endcase
   end

   assign done = run & tick & (cnt >= lim_m1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (tick && !done) cnt <= cnt + 1'b1;
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(sel)) |-> (cnt <= lim_m1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            trig_rise,
   input  logic [1:0]      mode,
   input  logic [CH_W-1:0] chan_top,
   input  logic            auto_go,
   input  logic            samp_done,
   input  logic            cv_done,
   output logic            sample_run,
   output logic            cv_start,
   output logic [CH_W-1:0] chan_sel,
   output logic            busy,
   output logic            load
);
   seq_state_e      st;
   seq_mode_e       m;
   logic [CH_W-1:0] chan, chan_nxt;
   logic            seq_end;

   assign m = seq_mode_e'(mode);

   always_comb begin
      seq_end  = (m == SEQ_ONE) || ((m == SEQ_SCAN) && (chan == '0));
      if (m == SEQ_REP_ONE)  chan_nxt = chan;
      else if (chan == '0)   chan_nxt = chan_top;
      else                   chan_nxt = chan - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         chan     <= '0;
         cv_start <= 1'b0;
      end else begin
         cv_start <= 1'b0;
         unique case (st)
            ST_IDLE: if (en && trig_rise) begin
               chan <= chan_top;
               st   <= ST_SAMPLE;
            end
            ST_SAMPLE: begin
               if (!en) st <= ST_IDLE;
               else if (samp_done) begin
                  st       <= ST_CONV;
                  cv_start <= 1'b1;
               end
            end
            ST_CONV: if (cv_done) begin
               if (!en || seq_end) st <= ST_IDLE;
               else begin
                  chan <= chan_nxt;
                  st   <= auto_go ? ST_SAMPLE : ST_WAIT;
               end
            end
            default: begin
               if (!en) st <= ST_IDLE;
               else if (trig_rise) st <= ST_SAMPLE;
            end
         endcase
      end
   end

   assign sample_run = (st == ST_SAMPLE);
   assign busy       = (st != ST_IDLE);
   assign load       = (st == ST_CONV) && cv_done;
   assign chan_sel   = chan;

   // R3
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> $past(en));
   // R4
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |=> !cv_start);
   // R6
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && en && (m == SEQ_SCAN) && (chan_sel != '0)) |=> (chan_sel == $past(chan_sel) - 1'b1));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
   parameter int RES_W = 10,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RES_W-1:0] data,
   input  logic             fmt_signed,
   input  logic             irq_ack,
   input  logic             flag_clear,
   input  logic             irq_en,
   output logic [OUT_W-1:0] result,
   output logic             irq_flag,
   output logic             irq_req
);
   localparam int EXT_W = OUT_W - RES_W;

   logic [RES_W-1:0] flipped;
   logic [OUT_W-1:0] fmt_val;

   assign flipped = {~data[RES_W-1], data[RES_W-2:0]};

   if (RES_W < 2) begin : g_bad_res
      $error("adc_result_reg: RES_W must be at least 2");
   end
   if (EXT_W > 0) begin : g_wide
      assign fmt_val = fmt_signed ? {{EXT_W{flipped[RES_W-1]}}, flipped}
                                  : {{EXT_W{1'b0}}, data};
   end else if (EXT_W == 0) begin : g_exact
      assign fmt_val = fmt_signed ? flipped : data;
   end else begin : g_bad_out
      $error("adc_result_reg: OUT_W narrower than RES_W");
      assign fmt_val = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result   <= '0;
         irq_flag <= 1'b0;
      end else begin
         if (load) begin
            result   <= fmt_val;
            irq_flag <= 1'b1;
         end else if (irq_ack || flag_clear) begin
            irq_flag <= 1'b0;
         end
      end
   end

   assign irq_req = irq_flag & irq_en;

   // R11
   flag_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> irq_flag);
   // R11
   req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_flag);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int RES_W = 10,
   parameter int OUT_W = 16,
   parameter int CH_W  = 4,
   parameter int NTMR  = 3,
   parameter int SEL_W = 2,
   parameter int HOLD0 = 4,
   parameter int HOLD1 = 8,
   parameter int HOLD2 = 16,
   parameter int HOLD3 = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic             sw_go,
   input  logic [1:0]       cfg_mode,
   input  logic [CH_W-1:0]  cfg_chan,
   input  logic             cfg_auto,
   input  logic [1:0]       cfg_hold,
   input  logic [SEL_W-1:0] cfg_src,
   input  logic             cfg_src_inv,
   input  logic             cfg_signed,
   input  logic             cfg_irq_en,
   input  logic             irq_ack,
   input  logic             flag_clear,
   input  logic [NTMR-1:0]  tmr_trig,
   input  logic             cv_tick,
   output logic             cv_start,
   input  logic             cv_done,
   input  logic [RES_W-1:0] cv_data,
   output logic [CH_W-1:0]  chan_sel,
   output logic             sample_win,
   output logic             busy,
   output logic [OUT_W-1:0] result,
   output logic             irq_flag,
   output logic             irq_req
);
   logic trig_rise, samp_done, load;

   adc_trig_sel #(.NTMR(NTMR), .SEL_W(SEL_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .tmr_trig(tmr_trig),
      .src(cfg_src), .src_inv(cfg_src_inv), .trig_rise(trig_rise));

   adc_sample_timer #(.HOLD0(HOLD0), .HOLD1(HOLD1), .HOLD2(HOLD2), .HOLD3(HOLD3)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(sample_win), .tick(cv_tick),
      .sel(cfg_hold), .done(samp_done));

   adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(cfg_enable), .trig_rise(trig_rise),
      .mode(cfg_mode), .chan_top(cfg_chan), .auto_go(cfg_auto),
      .samp_done(samp_done), .cv_done(cv_done), .sample_run(sample_win),
      .cv_start(cv_start), .chan_sel(chan_sel), .busy(busy), .load(load));

   adc_result_reg #(.RES_W(RES_W), .OUT_W(OUT_W)) u_res (
      .clk(clk), .rst_n(rst_n), .load(load), .data(cv_data),
      .fmt_signed(cfg_signed), .irq_ack(irq_ack), .flag_clear(flag_clear),
      .irq_en(cfg_irq_en), .result(result), .irq_flag(irq_flag), .irq_req(irq_req));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, cfg_enable, sw_go, cfg_auto, cfg_src_inv, cfg_signed, cfg_irq_en;
   logic        flag_clear, cv_tick, cv_done, ack_main, ack_resp, irq_ack;
   logic [1:0]  cfg_mode, cfg_hold, cfg_src;
   logic [3:0]  cfg_chan, chan_sel;
   logic [2:0]  tmr_trig;
   logic [9:0]  cv_data;
   logic        cv_start, sample_win, busy, irq_flag, irq_req;
   logic [15:0] result;

   assign irq_ack = ack_main | ack_resp;

   adc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .sw_go(sw_go),
      .cfg_mode(cfg_mode), .cfg_chan(cfg_chan), .cfg_auto(cfg_auto),
      .cfg_hold(cfg_hold), .cfg_src(cfg_src), .cfg_src_inv(cfg_src_inv),
      .cfg_signed(cfg_signed), .cfg_irq_en(cfg_irq_en), .irq_ack(irq_ack),
      .flag_clear(flag_clear), .tmr_trig(tmr_trig), .cv_tick(cv_tick),
      .cv_start(cv_start), .cv_done(cv_done), .cv_data(cv_data),
      .chan_sel(chan_sel), .sample_win(sample_win), .busy(busy),
      .result(result), .irq_flag(irq_flag), .irq_req(irq_req));

   int total = 0, bad = 0;
   int n_start = 0, conv_cnt = 0, wcnt = 0, last_win = 0;
   int chan_log [0:255];
   int win_log  [0:255];
   bit collide = 1'b0;

   function automatic int hold_len(input logic [1:0] h);
      case (h)
         2'd0: return 4;
         2'd1: return 8;
         2'd2: return 16;
         default: return 64;
      endcase
   endfunction

   function automatic logic [15:0] fmt_ref(input logic [9:0] d, input logic s);
      logic msb;
      msb = ~d[9];
      if (s) return {{6{msb}}, msb, d[8:0]};
      return {6'b0, d};
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick_mon();
      @(negedge clk);
      if (sample_win) wcnt++;
      else if (wcnt != 0) begin
         last_win = wcnt;
         wcnt = 0;
      end
   endtask

   // converter model
   initial begin
      cv_done = 1'b0; cv_data = '0; ack_resp = 1'b0;
      forever begin
         tick_mon();
         if (cv_start) begin
            logic [9:0] d;
            chan_log[n_start & 255] = int'(chan_sel);
            win_log[n_start & 255]  = last_win;
            n_start++;
            repeat (1 + $urandom % 3) tick_mon();
            d = 10'($urandom);
            cv_data = d; cv_done = 1'b1;
            if (collide) ack_resp = 1'b1;
            tick_mon();
            cv_done = 1'b0; ack_resp = 1'b0;
            chk(result == fmt_ref(d, cfg_signed), "R10", "stored result", int'(result), int'(fmt_ref(d, cfg_signed)));
            chk(irq_flag == 1'b1, "R11", "flag after load", int'(irq_flag), 1);
            conv_cnt++;
         end
      end
   end

   task automatic sw_pulse();
      @(negedge clk) sw_go = 1'b1;
      @(negedge clk) sw_go = 1'b0;
   endtask

   task automatic tmr_pulse(input int i);
      @(negedge clk) tmr_trig[i] = ~tmr_trig[i];
      @(negedge clk) tmr_trig[i] = ~tmr_trig[i];
   endtask

   task automatic wait_cnt(input int k);
      while (conv_cnt < k) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int s, c;
      void'($urandom(32'h5eed));
      rst_n = 1'b0; cfg_enable = 0; sw_go = 0; cfg_auto = 0; cfg_src_inv = 0;
      cfg_signed = 0; cfg_irq_en = 0; flag_clear = 0; cv_tick = 1; ack_main = 0;
      cfg_mode = 0; cfg_hold = 0; cfg_src = 0; cfg_chan = 0; tmr_trig = 3'b000;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && sample_win == 0 && cv_start == 0, "R1", "status in reset", int'({busy, sample_win, cv_start}), 0);
      chk(result == 0 && irq_flag == 0 && irq_req == 0 && chan_sel == 0, "R1", "outputs in reset", int'(result), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy == 0 && result == 0 && irq_flag == 0, "R1", "after reset", int'({busy, irq_flag}), 0);

      // R3: trigger while disabled is ignored
      s = n_start;
      sw_pulse();
      repeat (30) @(negedge clk);
      cfg_enable = 1'b1;
      repeat (20) @(negedge clk);
      chk(n_start == s && busy == 0, "R3", "start while disabled", n_start - s, 0);

      // R5/R4: single conversion for every window length; R3 enable with start same cycle
      for (int h = 0; h < 4; h++) begin
         cfg_enable = 1'b0; cfg_mode = 2'd0; cfg_hold = 2'(h); cfg_chan = 4'(5 + h);
         repeat (2) @(negedge clk);
         s = n_start; c = conv_cnt;
         @(negedge clk) begin cfg_enable = 1'b1; sw_go = 1'b1; end
         @(negedge clk) sw_go = 1'b0;
         @(negedge clk);
         chk(busy == 1'b1, "R12", "busy after trigger", int'(busy), 1);
         wait_cnt(c + 1);
         chk(busy == 1'b0, "R5", "idle after single", int'(busy), 0);
         chk(chan_log[s & 255] == 5 + h, "R5", "single channel", chan_log[s & 255], 5 + h);
         chk(win_log[s & 255] == hold_len(2'(h)), "R4", "window length", win_log[s & 255], hold_len(2'(h)));
         chk(n_start == s + 1, "R5", "one start only", n_start - s, 1);
      end

      // R4: stalled converter clock lengthens the window
      cfg_hold = 2'd1; cfg_chan = 4'd2;
      s = n_start; c = conv_cnt;
      sw_pulse();
      while (!sample_win) @(negedge clk);
      cv_tick = 1'b0;
      repeat (10) @(negedge clk);
      cv_tick = 1'b1;
      wait_cnt(c + 1);
      chk(win_log[s & 255] == 18, "R4", "stalled window", win_log[s & 255], 18);

      // R6/R8: scan once, one trigger per step
      cfg_mode = 2'd1; cfg_chan = 4'd3; cfg_auto = 1'b0; cfg_hold = 2'd0;
      s = n_start; c = conv_cnt;
      sw_pulse();
      for (int k = 0; k < 4; k++) begin
         wait_cnt(c + k + 1);
         if (k == 0) begin
            repeat (20) @(negedge clk);
            chk(n_start == s + 1, "R8", "no step without edge", n_start - s, 1);
         end
         if (k < 3) begin
            chk(busy == 1'b1, "R12", "busy between steps", int'(busy), 1);
            sw_pulse();
         end
      end
      wait_idle();
      chk(busy == 1'b0 && n_start == s + 4, "R6", "scan count", n_start - s, 4);
      for (int k = 0; k < 4; k++)
         chk(chan_log[(s + k) & 255] == 3 - k, "R6", "scan channel", chan_log[(s + k) & 255], 3 - k);

      // R8: auto-continue scan
      cfg_auto = 1'b1; cfg_chan = 4'd2;
      s = n_start; c = conv_cnt;
      sw_pulse();
      wait_cnt(c + 3);
      wait_idle();
      chk(n_start == s + 3, "R8", "auto scan count", n_start - s, 3);
      for (int k = 0; k < 3; k++)
         chk(chan_log[(s + k) & 255] == 2 - k, "R8", "auto scan channel", chan_log[(s + k) & 255], 2 - k);

      // R7/R9: repeat scan with auto, stopped by enable drop
      cfg_mode = 2'd3; cfg_chan = 4'd1;
      s = n_start; c = conv_cnt;
      sw_pulse();
      wait_cnt(c + 5);
      cfg_enable = 1'b0;
      wait_idle();
      repeat (6) @(negedge clk);
      chk(n_start - s >= 5 && n_start - s <= 7, "R7", "repeat scan count", n_start - s, 6);
      chk(conv_cnt - c == n_start - s, "R9", "started conversions finish", conv_cnt - c, n_start - s);
      for (int k = 0; k < 5; k++)
         chk(chan_log[(s + k) & 255] == ((k % 2 == 0) ? 1 : 0), "R7", "scan reload", chan_log[(s + k) & 255], (k % 2 == 0) ? 1 : 0);

      // R2/R7: repeat single on inverted timer input 1
      cfg_mode = 2'd2; cfg_chan = 4'd9; cfg_auto = 1'b0; cfg_src = 2'd2; cfg_src_inv = 1'b1;
      tmr_trig = 3'b111;
      repeat (3) @(negedge clk);
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      s = n_start; c = conv_cnt;
      for (int k = 0; k < 3; k++) begin
         tmr_pulse(1);
         wait_cnt(c + k + 1);
      end
      chk(busy == 1'b1, "R12", "busy waiting in repeat", int'(busy), 1);
      tmr_pulse(0);
      tmr_pulse(2);
      repeat (20) @(negedge clk);
      chk(n_start == s + 3, "R2", "unselected input ignored", n_start - s, 3);
      for (int k = 0; k < 3; k++)
         chk(chan_log[(s + k) & 255] == 9, "R7", "repeat channel", chan_log[(s + k) & 255], 9);
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R9", "stop from wait", int'(busy), 0);
      cfg_src_inv = 1'b0; tmr_trig = 3'b000;
      repeat (3) @(negedge clk);

      // R9: abort inside an open window
      cfg_mode = 2'd0; cfg_hold = 2'd3; cfg_src = 2'd0; cfg_enable = 1'b1;
      repeat (2) @(negedge clk);
      s = n_start;
      sw_pulse();
      repeat (10) @(negedge clk);
      chk(sample_win == 1'b1, "R9", "window open", int'(sample_win), 1);
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      chk(sample_win == 0 && busy == 0, "R9", "window abandoned", int'({sample_win, busy}), 0);
      repeat (80) @(negedge clk);
      chk(n_start == s, "R9", "no start after abort", n_start - s, 0);

      // R11: flag and request
      cfg_enable = 1'b1; cfg_hold = 2'd0; cfg_irq_en = 1'b0;
      c = conv_cnt;
      sw_pulse();
      wait_cnt(c + 1);
      chk(irq_req == 1'b0 && irq_flag == 1'b1, "R11", "request masked", int'(irq_req), 0);
      cfg_irq_en = 1'b1;
      @(negedge clk);
      chk(irq_req == 1'b1, "R11", "request enabled", int'(irq_req), 1);
      @(negedge clk) flag_clear = 1'b1;
      @(negedge clk) flag_clear = 1'b0;
      chk(irq_flag == 1'b0 && irq_req == 1'b0, "R11", "software clear", int'(irq_flag), 0);
      collide = 1'b1;
      c = conv_cnt;
      sw_pulse();
      wait_cnt(c + 1);
      collide = 1'b0;
      chk(irq_flag == 1'b1, "R11", "load beats ack", int'(irq_flag), 1);
      @(negedge clk) ack_main = 1'b1;
      @(negedge clk) ack_main = 1'b0;
      chk(irq_flag == 1'b0, "R11", "ack clears", int'(irq_flag), 0);

      // R2/R4/R5/R10: random single conversions over sources and formats
      for (int it = 0; it < 24; it++) begin
         int src, ch, h;
         src = $urandom % 4; ch = $urandom % 16; h = $urandom % 3;
         cfg_enable = 1'b0;
         cfg_src = 2'(src); cfg_chan = 4'(ch); cfg_hold = 2'(h); cfg_signed = 1'($urandom);
         repeat (2) @(negedge clk);
         cfg_enable = 1'b1;
         @(negedge clk);
         s = n_start; c = conv_cnt;
         if (src == 0) sw_pulse();
         else tmr_pulse(src - 1);
         wait_cnt(c + 1);
         chk(chan_log[s & 255] == ch, "R2", "random channel", chan_log[s & 255], ch);
         chk(win_log[s & 255] == hold_len(2'(h)), "R4", "random window", win_log[s & 255], hold_len(2'(h)));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule